// File: doc/BRIEF.md
# Parallel-Chain Scan Self-Test Sequencer

This block runs a scan-based self-test over several parallel scan chains. A Galois LFSR makes the stimulus. An XOR phase-shifting network turns the LFSR state into one serial input per chain, so that neighbouring chains do not get delayed copies of the same bit stream. A MISR with one input per chain compacts the bits that come out of the chains.

After a start pulse, the sequencer fills every chain with one shift pass of CLEN cycles, with scan-enable high. It then drops scan-enable for exactly one functional capture cycle. The next shift pass unloads the captured responses into the MISR and, in the same cycles, loads the next pattern. After the last pattern there is one final unload-only pass. The block then raises done and holds the signature.

The logic under test sits outside the block. It is wired between the chain serial inputs and outputs, and it captures on the capture strobe.

Top module: `scan_bist_seq`

## Requirements
- R1: While reset is active and right after it, scan_en, capture and done are 0 and signature is all zeros.
- R2: A start pulse sampled while idle or done does four things: it loads the LFSR with the seed (default 16'hACE1), clears the MISR to zero, clears done, and begins a shift pass on the next cycle.
- R3: With a pattern count P sampled at start, the sequencer runs exactly P+1 shift passes. Each pass is CLEN consecutive cycles with scan_en high, for (P+1)*CLEN scan cycles in total.
- R4: Between consecutive shift passes there is exactly one capture cycle, with capture high and scan_en low. A run has P capture cycles in total, and each one directly follows a scan cycle.
- R5: The LFSR steps once per scan cycle as state' = (state >> 1) ^ (state[0] ? 16'hB400 : 0). Chain input i equals lfsr[i mod 16] ^ lfsr[(3i+7) mod 16] of the current state. In the first scan cycle this is computed from the seed.
- R6: In every scan cycle after the first pass, the MISR updates as m' = {m[NCH-2:0],0} ^ (m[NCH-1] ? POLY : 0) ^ chain_so, where POLY defaults to 4'b0011. Bit i of chain_so is the serial output of chain i.
- R7: The MISR does not change during the first shift pass, so chain contents left from before start have no effect on the signature. With P = 0 the run ends with an all-zero signature.
- R8: done rises on the cycle after the last scan cycle, so it is observed (P+1)*CLEN+P+1 cycles after the start edge. It then stays high, with signature stable and both scan_en and capture low, until the next start.
- R9: A start pulse during a run has no effect on timing or signature.
- R10: pat_count is sampled only at start; changing it during a run has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a self-test run |
| pat_count | input | PCW | Number of patterns, sampled at start |
| scan_en | output | 1 | Chains shift on this cycle |
| capture | output | 1 | Functional capture cycle |
| chain_si | output | NCH | Serial input to each chain |
| chain_so | input | NCH | Serial output of each chain |
| done | output | 1 | Run complete, signature valid |
| signature | output | NCH | MISR contents |

## Verification
Directed runs with P = 0, 1 and the largest count used isolate different things:
- P = 0 shows that a load-only pass leaves the MISR untouched.
- P = 1 shows the plain load/capture/unload sequence.
- Larger counts show that the overlapped unload-and-load keeps pattern boundaries aligned.

Random counts combine with random garbage preloaded into the chains. A signature that matches despite the garbage proves that the first pass is excluded from compaction, while a wrong phase-shifter tap or a wrong MISR feedback shows up as a mismatch. Runs disturbed by a stray start pulse and a changed count separate a correct once-at-start sampling from a sequencer that restarts or re-reads its inputs.

// File: rtl/scan_bist_seq.sv
module scan_bist_seq #(
  parameter int NCH  = 4,
  parameter int CLEN = 8,
  parameter int PCW  = 8,
  parameter int LW   = 16,
  parameter logic [LW-1:0]  LFSR_TAPS = 16'hB400,
  parameter logic [LW-1:0]  LFSR_SEED = 16'hACE1,
  parameter logic [NCH-1:0] MISR_POLY = NCH'(3)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [PCW-1:0] pat_count,
  output logic           scan_en,
  output logic           capture,
  output logic [NCH-1:0] chain_si,
  input  logic [NCH-1:0] chain_so,
  output logic           done,
  output logic [NCH-1:0] signature
);
  localparam int CW = (CLEN > 1) ? $clog2(CLEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLEN - 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_CAPT, S_DONE} st_t;

  st_t            st;
  logic [LW-1:0]  lfsr, lfsr_nx;
  logic [NCH-1:0] misr, misr_nx;
  logic [CW-1:0]  cnt;
  logic [PCW-1:0] loads;
  logic           first;

  assign scan_en   = (st == S_SHIFT);
  assign capture   = (st == S_CAPT);
  assign done      = (st == S_DONE);
  assign signature = misr;

  assign lfsr_nx = (lfsr >> 1) ^ (lfsr[0] ? LFSR_TAPS : '0);
  assign misr_nx = {misr[NCH-2:0], 1'b0} ^ (misr[NCH-1] ? MISR_POLY : '0) ^ chain_so;

  for (genvar i = 0; i < NCH; i++) begin : g_phase
    assign chain_si[i] = lfsr[i % LW] ^ lfsr[(3*i + 7) % LW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      lfsr  <= LFSR_SEED;
      misr  <= '0;
      cnt   <= '0;
      loads <= '0;
      first <= 1'b1;
    end else begin
      case (st)
        S_IDLE, S_DONE: if (start) begin
          st    <= S_SHIFT;
          lfsr  <= LFSR_SEED;
          misr  <= '0;
          cnt   <= '0;
          loads <= pat_count;
          first <= 1'b1;
        end
        S_SHIFT: begin
          lfsr <= lfsr_nx;
          if (!first) misr <= misr_nx;
          if (cnt == LAST) begin
            cnt <= '0;
            if (loads != '0) begin
              loads <= loads - 1'b1;
              st    <= S_CAPT;
            end else begin
              st <= S_DONE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          first <= 1'b0;
          st    <= S_SHIFT;
        end
      endcase
    end
  end

  p_capture_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> !scan_en);
  p_capture_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> !capture);
  p_capture_after_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(capture) |-> $past(scan_en));
  p_first_pass_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && first) |=> (misr == '0));
  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(signature)));
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!scan_en && !capture));
  p_busy_ignores_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && start && cnt != LAST) |=> scan_en);
endmodule

// File: tb/sim_scan_bist_seq.sv
module sim_scan_bist_seq;
  localparam int NCH = 4, CLEN = 8, PCW = 8, LW = 16;
  localparam logic [LW-1:0]  SEED = 16'hACE1, TAPS = 16'hB400;
  localparam logic [NCH-1:0] POLY = 4'b0011;

  typedef logic [CLEN-1:0] chains_t [NCH];

  logic clk = 0, rst_n = 0, start = 0;
  logic [PCW-1:0] pat_count = '0;
  logic scan_en, capture, done;
  logic [NCH-1:0] chain_si, chain_so, signature;

  int checks = 0, fails = 0;
  chains_t ch, pre_val;
  logic pre_req = 0;

  always #2 clk = ~clk;

  scan_bist_seq #(.NCH(NCH), .CLEN(CLEN), .PCW(PCW), .LW(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .pat_count(pat_count),
    .scan_en(scan_en), .capture(capture), .chain_si(chain_si),
    .chain_so(chain_so), .done(done), .signature(signature));

  function automatic chains_t cut_fn(input chains_t c);
    chains_t n;
    for (int i = 0; i < NCH; i++)
      n[i] = c[(i+1) % NCH] ^ {c[i][0], c[i][CLEN-1:1]} ^ CLEN'(90 + 17*i);
    return n;
  endfunction

  function automatic logic [NCH-1:0] phase_fn(input logic [LW-1:0] l);
    logic [NCH-1:0] v;
    for (int i = 0; i < NCH; i++) v[i] = l[i % LW] ^ l[(3*i + 7) % LW];
    return v;
  endfunction

  for (genvar i = 0; i < NCH; i++) begin : g_so
    assign chain_so[i] = ch[i][CLEN-1];
  end

  always_ff @(posedge clk) begin
    if (pre_req) ch <= pre_val;
    else if (scan_en) for (int i = 0; i < NCH; i++) ch[i] <= {ch[i][CLEN-2:0], chain_si[i]};
    else if (capture) ch <= cut_fn(ch);
  end

  int nscan = 0, ncap = 0;
  always @(posedge clk) begin
    if (scan_en) nscan++;
    if (capture) ncap++;
  end

  function automatic logic [NCH-1:0] model_sig(input int p);
    logic [LW-1:0] l;
    logic [NCH-1:0] m, si, so;
    chains_t c;
    l = SEED; m = '0;
    for (int i = 0; i < NCH; i++) c[i] = '0;
    for (int ph = 0; ph <= p; ph++) begin
      for (int b = 0; b < CLEN; b++) begin
        si = phase_fn(l);
        for (int i = 0; i < NCH; i++) so[i] = c[i][CLEN-1];
        if (ph > 0) m = {m[NCH-2:0], 1'b0} ^ (m[NCH-1] ? POLY : '0) ^ so;
        for (int i = 0; i < NCH; i++) c[i] = {c[i][CLEN-2:0], si[i]};
        l = (l >> 1) ^ (l[0] ? TAPS : '0);
      end
      if (ph < p) c = cut_fn(c);
    end
    return m;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic preload();
    @(negedge clk);
    for (int i = 0; i < NCH; i++) pre_val[i] = CLEN'($urandom);
    pre_req = 1;
    @(negedge clk);
    pre_req = 0;
  endtask

  task automatic run_pat(input int p, input bit disturb);
    int k, s0, c0, exp_n;
    logic [NCH-1:0] es;
    exp_n = (p+1)*CLEN + p + 1;
    es = model_sig(p);
    @(negedge clk);
    pat_count = PCW'(p);
    start = 1;
    s0 = nscan; c0 = ncap;
    @(negedge clk);
    start = 0;
    chk(scan_en == 1 && done == 0, "R2 run begins", {scan_en, done}, 2'b10);
    chk(chain_si == phase_fn(SEED), "R5 first chain inputs", chain_si, phase_fn(SEED));
    k = 1;
    while (!done && k < 5000) begin
      @(negedge clk);
      k++;
      if (disturb && k == 5) begin start = 1; pat_count = PCW'(p + 3); end
      if (disturb && k == 6) start = 0;
    end
    chk(k == exp_n, disturb ? "R9 R10 done latency" : "R8 done latency", k, exp_n);
    chk(nscan - s0 == (p+1)*CLEN, "R3 scan cycles", nscan - s0, (p+1)*CLEN);
    chk(ncap - c0 == p, "R4 capture cycles", ncap - c0, p);
    chk(signature == es, p == 0 ? "R7 zero-pattern signature" : "R6 signature", signature, es);
    repeat (3) @(negedge clk);
    chk(done && signature == es && !scan_en && !capture, "R8 hold", {done, signature}, {1'b1, es});
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NCH; i++) pre_val[i] = '0;
    for (int i = 0; i < NCH; i++) ch[i] = '0;
    repeat (3) @(negedge clk);
    chk(!scan_en && !capture && !done && signature == '0, "R1 reset state",
        {scan_en, capture, done, signature}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!scan_en && !capture && !done && signature == '0, "R1 after reset",
        {scan_en, capture, done, signature}, 0);
    run_pat(0, 0);
    run_pat(1, 0);
    run_pat(5, 0);
    run_pat(5, 0);
    preload();
    run_pat(0, 0);
    preload();
    run_pat(3, 0);
    run_pat(4, 1);
    for (int t = 0; t < 8; t++) begin
      preload();
      run_pat(int'($urandom_range(0, 9)), t[0]);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4*150000);
    checks++; fails++;
    $display("FAIL R8 watchdog: actual 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule